// File: doc/BRIEF.md
# Presettable Johnson divide-by-N counter

A five-stage twisted-ring counter that divides its clock by any integer from 2 to 10. Each stage is a register, and every stage value is visible at the ports. On each rising clock edge, the first stage takes a computed feedback bit and every later stage takes the value of the stage before it.

The ratio input picks the feedback:
- **Even N = 2k:** the feedback is the inverse of stage k.
- **Odd N = 2k-1:** the feedback is the NAND of stages k and k-1. This drops one state from the ring.

Stage k, the last active stage, also drives a divided output. That output is high for k clocks of every N.

Reset and preset are both synchronous:
- A high reset clears the ring.
- A high preset enable loads five jam bits into the stages.

Jam values and upsets can leave the ring holding a pattern that is not a Johnson state. Anti-lock gating detects such a pattern and shifts zeros into the ring until it is back on its proper sequence.

Top module: `jcount_divn`

## Requirements
- R1: When `rst` is high at a rising edge, all stages are 0 after that edge, whatever `preset_en` and `jam` hold.
- R2: When `preset_en` is high and `rst` is low at a rising edge, the stages equal `jam` after that edge (`jam[0]` goes to stage 1), whatever the ratio and the current state.
- R3: With `rst` and `preset_en` low, each rising edge moves stage i into stage i+1, and `q[0]` (stage 1) takes the feedback bit.
- R4: For an even ratio N = 2k, the feedback is the inverse of stage k (`q[k-1]`). From reset the ring then walks the 2k Johnson states.
- R5: For an odd ratio N = 2k-1 (k from 2 to 5), the feedback is NOT(`q[k-1]` AND `q[k-2]`). The ring then repeats with period N.
- R6: A `ratio` value of 0, 1 or 11 to 15 behaves exactly as ratio 10.
- R7: The active stages are `q[0]` to `q[k-1]`. If more than one adjacent pair among them differ, the pattern is illegal and the feedback bit is 0. An illegal pattern becomes legal within N clocks and stays legal while the ratio is held.
- R8: `div_out` equals stage k (`q[k-1]`), where k = (N+1)/2. Once the ring is legal, `div_out` has period exactly N, with k high clocks and one rising edge per period. This holds both after reset and after any jam preset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the ring advances on its rising edge |
| rst | input | 1 | Synchronous active-high clear, highest priority |
| preset_en | input | 1 | Synchronous active-high load of `jam` |
| jam | input | 5 | Preset value; bit 0 goes to stage 1 |
| ratio | input | 4 | Division ratio N, 2 to 10 (other values give 10) |
| q | output | 5 | Registered stage outputs; bit 0 is stage 1 |
| div_out | output | 1 | Divided clock, equal to stage (N+1)/2 |

## Verification
Reset, preset and every shift appear on `q` one rising edge after the inputs are applied. `div_out` is a mux of the stages, so it moves in the same cycle as `q`.

The bench drives inputs 1 ns after an edge and samples 1 ns after the next edge, so each check reads exactly one edge of effect. Anti-lock recovery is given up to N edges before the bench tests for a legal pattern. Period and duty are judged over a window of 3N samples, taken only after 2N settling edges.

// File: rtl/jc_pkg.sv
package jc_pkg;
  typedef enum logic {
    FB_EVEN = 1'b0,
    FB_ODD  = 1'b1
  } fb_kind_e;
endpackage

// File: rtl/jc_ratio_decode.sv
module jc_ratio_decode
  import jc_pkg::*;
#(
  parameter int STAGES = 5,
  parameter int RW     = $clog2(2 * STAGES + 1),
  parameter int TW     = $clog2(STAGES + 1)
) (
  input  logic [RW-1:0] ratio,
  output logic [TW-1:0] tap,
  output fb_kind_e      kind
);
  localparam int MAXN = 2 * STAGES;

  // Out-of-range ratios fall back to the largest division (R6)
  always_comb begin
    int n;
    n = int'(ratio);
    if (n < 2 || n > MAXN) n = MAXN;
    tap  = TW'((n + 1) / 2);
    kind = n[0] ? FB_ODD : FB_EVEN;
  end
endmodule

// File: rtl/jc_feedback.sv
module jc_feedback
  import jc_pkg::*;
#(
  parameter int STAGES = 5,
  parameter int TW     = $clog2(STAGES + 1)
) (
  input  logic [STAGES-1:0] q,
  input  logic [TW-1:0]     tap,
  input  fb_kind_e          kind,
  output logic              d,
  output logic              legal
);
  logic [STAGES-2:0] diff;
  logic              q_last;
  logic              q_prev;

  // An edge counts only when both neighbours lie inside the active ring
  for (genvar i = 0; i < STAGES - 1; i++) begin : g_edge
    assign diff[i] = (q[i] ^ q[i+1]) & ((i + 1) < int'(tap));
  end

  assign legal = ($countones(diff) <= 1);

  always_comb begin
    q_last = 1'b0;
    q_prev = 1'b0;
    for (int i = 0; i < STAGES; i++) begin
      if (i == int'(tap) - 1) q_last = q[i];
      if (i == int'(tap) - 2) q_prev = q[i];
    end
  end

  // Anti-lock: an illegal pattern is flushed with zeros (R7)
  always_comb begin
    if (!legal)              d = 1'b0;
    else if (kind == FB_ODD) d = ~(q_last & q_prev);
    else                     d = ~q_last;
  end
endmodule

// File: rtl/jc_stages.sv
module jc_stages #(
  parameter int STAGES = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [STAGES-1:0] jam,
  input  logic              d,
  output logic [STAGES-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= jam;
    else           q <= {q[STAGES-2:0], d};
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (q == '0)); // R1
  AST_PRESET_LOADS: assert property (@(posedge clk) disable iff (rst)
    load |=> (q == $past(jam))); // R2
  AST_SHIFT_CHAIN: assert property (@(posedge clk) disable iff (rst)
    !load |=> (q[STAGES-1:1] == $past(q[STAGES-2:0]))); // R3
  AST_FIRST_STAGE: assert property (@(posedge clk) disable iff (rst)
    !load |=> (q[0] == $past(d))); // R3
endmodule

// File: rtl/jcount_divn.sv
module jcount_divn
  import jc_pkg::*;
#(
  parameter int STAGES = 5,
  localparam int RW    = $clog2(2 * STAGES + 1),
  localparam int TW    = $clog2(STAGES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              preset_en,
  input  logic [STAGES-1:0] jam,
  input  logic [RW-1:0]     ratio,
  output logic [STAGES-1:0] q,
  output logic              div_out
);
  logic [TW-1:0] tap;
  fb_kind_e      kind;
  logic          d_in;
  logic          legal;

  jc_ratio_decode #(.STAGES(STAGES), .RW(RW), .TW(TW)) u_dec (
    .ratio (ratio),
    .tap   (tap),
    .kind  (kind)
  );

  jc_feedback #(.STAGES(STAGES), .TW(TW)) u_fb (
    .q     (q),
    .tap   (tap),
    .kind  (kind),
    .d     (d_in),
    .legal (legal)
  );

  jc_stages #(.STAGES(STAGES)) u_ring (
    .clk  (clk),
    .rst  (rst),
    .load (preset_en),
    .jam  (jam),
    .d    (d_in),
    .q    (q)
  );

  // Divided output is the last active stage (R8)
  always_comb begin
    div_out = q[0];
    for (int i = 0; i < STAGES; i++)
      if (i == int'(tap) - 1) div_out = q[i];
  end

  AST_TAP_RANGE: assert property (@(posedge clk) disable iff (rst)
    (tap >= TW'(1)) && (int'(tap) <= STAGES)); // R6
  AST_LEGAL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!preset_en && legal) |=> (legal || (ratio != $past(ratio)))); // R7
  AST_RESET_LEGAL: assert property (@(posedge clk) rst |=> legal); // R7
endmodule

// File: tb/tb_jcount_divn.sv
module tb_jcount_divn;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       preset_en = 1'b0;
  logic [4:0] jam = '0;
  logic [3:0] ratio = 4'd10;
  logic [4:0] q;
  logic       div_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  jcount_divn dut (
    .clk(clk), .rst(rst), .preset_en(preset_en), .jam(jam),
    .ratio(ratio), .q(q), .div_out(div_out)
  );

  always #4 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int norm_n(input int r);
    return (r < 2 || r > 10) ? 10 : r;
  endfunction

  function automatic bit tb_legal(input logic [4:0] s, input int k);
    int e = 0;
    for (int i = 0; i < k - 1; i++) if (s[i] != s[i+1]) e++;
    return e <= 1;
  endfunction

  function automatic logic [4:0] tb_next(input logic [4:0] s, input int r);
    int n = norm_n(r);
    int k = (n + 1) / 2;
    logic d;
    if (!tb_legal(s, k))  d = 1'b0;
    else if (n % 2 == 1)  d = ~(s[k-1] & s[k-2]);
    else                  d = ~s[k-1];
    return {s[3:0], d};
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    tick();
    rst = 1'b0;
  endtask

  // R1: reset clears and outranks preset
  task automatic t_reset();
    rst = 1'b1; preset_en = 1'b1; jam = 5'b10110;
    tick();
    chk(q == 5'd0, "R1", "reset beats preset", q, 0);
    preset_en = 1'b0;
    tick();
    chk(q == 5'd0, "R1", "reset held", q, 0);
    rst = 1'b0;
  endtask

  // R2: preset loads jam and outranks shifting
  task automatic t_preset();
    logic [4:0] pats [3] = '{5'b10101, 5'b01100, 5'b11111};
    for (int i = 0; i < 3; i++) begin
      preset_en = 1'b1; jam = pats[i];
      tick();
      chk(q == pats[i], "R2", "jam load", q, pats[i]);
    end
    tick();
    chk(q == 5'b11111, "R2", "held preset no shift", q, 5'b11111);
    preset_en = 1'b0;
  endtask

  // R3 with R4/R5: stage sequence from reset matches the ring rule
  task automatic t_sequence(input int r, input string req);
    logic [4:0] exp_q = '0;
    ratio = 4'(r);
    do_reset();
    chk(q == 5'd0, "R1", "start", q, 0);
    for (int c = 0; c < 2 * norm_n(r); c++) begin
      exp_q = tb_next(exp_q, r);
      tick();
      chk(q == exp_q, req, $sformatf("R3 step ratio %0d", r), q, exp_q);
    end
  endtask

  // R8: period and duty of div_out
  task automatic t_period(input int r, input bit use_jam, input logic [4:0] jv,
                          input string req);
    int n = norm_n(r);
    int k = (n + 1) / 2;
    bit w [30];
    int ones, rises;
    ratio = 4'(r);
    do_reset();
    if (use_jam) begin
      preset_en = 1'b1; jam = jv;
      tick();
      preset_en = 1'b0;
    end
    for (int c = 0; c < 2 * n; c++) tick();
    for (int c = 0; c < 3 * n; c++) begin
      w[c] = div_out;
      tick();
    end
    ones = 0; rises = 0;
    for (int c = 0; c < n; c++) begin
      if (w[c]) ones++;
      if (w[c] != w[c+n]) rises = rises + 100;
      if (w[c+n] && !w[c+n-1]) rises++;
    end
    chk(ones == k, req, $sformatf("R8 high clocks N=%0d jam=%0d", n, use_jam), ones, k);
    chk(rises == 1, req, $sformatf("R8 period N=%0d jam=%0d", n, use_jam), rises, 1);
  endtask

  // R7: illegal pattern recovers within N clocks and stays legal
  task automatic t_antilock(input int r, input logic [4:0] jv);
    int n = norm_n(r);
    int k = (n + 1) / 2;
    int steps = -1;
    bit stay = 1'b1;
    ratio = 4'(r);
    do_reset();
    preset_en = 1'b1; jam = jv;
    tick();
    preset_en = 1'b0;
    for (int c = 1; c <= 3 * n; c++) begin
      tick();
      if (steps < 0 && tb_legal(q, k)) steps = c;
      else if (steps >= 0 && !tb_legal(q, k)) stay = 1'b0;
    end
    chk(steps >= 0 && steps <= n, "R7", $sformatf("recovery N=%0d", n), steps, n);
    chk(stay, "R7", "stays legal", stay, 1);
  endtask

  initial begin
    tick();
    chk(q == 5'd0, "R1", "reset state", q, 0);
    chk(div_out == 1'b0, "R8", "reset div_out", div_out, 0);
    t_reset();
    t_preset();
    t_sequence(10, "R4");
    t_sequence(4, "R4");
    t_sequence(7, "R5");
    t_sequence(3, "R5");
    for (int r = 2; r <= 10; r++) begin
      t_period(r, 1'b0, 5'd0, (r % 2 == 0) ? "R4" : "R5");
      t_period(r, 1'b1, 5'(r * 7 + 3), (r % 2 == 0) ? "R4" : "R5");
    end
    t_period(0, 1'b0, 5'd0, "R6");
    t_period(1, 1'b1, 5'b00110, "R6");
    t_period(13, 1'b0, 5'd0, "R6");
    t_sequence(15, "R6");
    t_antilock(10, 5'b00101);
    t_antilock(9, 5'b01010);
    t_antilock(5, 5'b00101);
    t_antilock(6, 5'b11101);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule